// File: doc/BRIEF.md
# Coprocessor Register Debug Scan Chain

This block is a debug data register that sits behind an existing test-access-port controller. It gives an external debugger read and write access to a small coprocessor register bank while the core is halted. The TAP controller supplies TCK, TDI and the capture, shift and update strobes. The block drives TDO and answers only when the selected scan chain number matches its own number and the internal-test instruction is loaded.

The debugger packs a command into one 48-bit scan. The command holds a data word, a request/ready bit, a four-field register address and a write-select bit. The access is launched on the update strobe and completes a fixed number of TCK cycles later. The debugger then repeats scans with the request bit clear (NOP scans). Each capture puts the ready state, and for a read the register value, into the chain, and the debugger keeps polling until the ready bit returns 1.

Top module: `cpdbg_chain`

## Requirements
- R1: The chain is active only when `chain_sel` equals 15 and `ir_intest` is 1. While it is inactive, capture, shift and update have no effect, no access starts and `tdo` is 0.
- R2: The chain is 48 bits long and is shifted LSB first. Bits 31:0 hold data, bit 32 holds the request/ready flag, bits 46:33 hold the register address and bit 47 holds the write-select flag. The first bit shifted in, and the first bit seen on `tdo` after a capture, is data bit 0.
- R3: The 14-bit address holds field A in bits 13:11, field B in bits 10:8, field N in bits 7:4 and field M in bits 3:0. Register k (k < NUM_REGS, default 8) is the address with A=0, B=0, M=0 and N=k.
- R4: An update with the request bit at 1 and the write-select bit at 1 stores the 32-bit data field into the addressed register.
- R5: An update with the request bit at 1 and the write-select bit at 0 reads the addressed register. The captured data field on the completing poll holds its value.
- R6: On every capture the data field holds the last read result, bit 32 holds 1 when no access is pending and 0 otherwise, and bits 47:33 are 0. After reset the captured word is 48'h1_0000_0000 and every register is 0.
- R7: An access launched at update edge U completes at edge U+LAT (LAT default 3). A capture at any edge from U+1 through U+LAT returns ready 0, and a capture at U+LAT+1 or later returns ready 1.
- R8: An update with the request bit at 0 is a NOP. It writes nothing and starts no access, so a capture at the next edge returns ready 1.
- R9: A read of an unimplemented address returns 0 and a write to one changes no register. Both still complete after LAT cycles.
- R10: A request that arrives while an access is pending is ignored. It neither restarts the completion timer nor replaces the pending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chain_sel | input | 4 | Scan chain number currently selected |
| ir_intest | input | 1 | Internal-test instruction is loaded |
| capture_dr | input | 1 | Capture strobe from the TAP controller |
| shift_dr | input | 1 | Shift strobe from the TAP controller |
| update_dr | input | 1 | Update strobe from the TAP controller |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |

## Verification
The hardest situation to reach is a capture or an update that lands inside the LAT-cycle pending window. A full scan lasts about 50 TCK cycles, so an ordinary poll always arrives after the access has finished. The bench therefore places a capture a chosen number of idle cycles after an update, at U+1, U+LAT and U+LAT+1, to pin down the exact completion edge. It also pulses a second update one cycle after a launch and checks that ready is back at U+LAT+1, which shows the timer was not restarted.

// File: rtl/cpdbg_pkg.sv
// Shared types for the coprocessor debug scan chain.
// Assumes a 48-bit chain. The field order is fixed because the host decodes it.
package cpdbg_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 14;
    localparam int CHAIN_W = DATA_W + ADDR_W + 2;

    // packed register address: field A, field B, field N, field M
    typedef struct packed {
        logic [2:0] fa;
        logic [2:0] fb;
        logic [3:0] fn;
        logic [3:0] fm;
    } cp_addr_t;

    // chain image: MSB write-select, address, request/ready, data (LSB first out)
    typedef struct packed {
        logic              wsel;
        cp_addr_t          addr;
        logic              req;
        logic [DATA_W-1:0] data;
    } chain_t;
endpackage

// File: rtl/cpdbg_shift.sv
// Serial shift register of the chain.
// Capture loads a parallel word, shift moves TDI in at the MSB.
// Assumes the strobes are already gated by chain selection.
module cpdbg_shift
    import cpdbg_pkg::*;
(
    input  logic   tck,
    input  logic   rst_n,
    input  logic   cap,
    input  logic   shf,
    input  logic   tdi,
    input  chain_t cap_word,
    output chain_t sr_q
);
    // capture has priority over shift; reset clears the chain
    always_ff @(posedge tck) begin
        if (!rst_n)   sr_q <= '0;
        else if (cap) sr_q <= cap_word;
        else if (shf) sr_q <= {tdi, sr_q[CHAIN_W-1:1]};
    end
endmodule

// File: rtl/cpdbg_seq.sv
// Access sequencer: holds an access pending for LAT cycles after a start.
// Assumes LAT >= 1. A start while busy is ignored.
module cpdbg_seq #(
    parameter int LAT = 3
) (
    input  logic tck,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(LAT + 1);

    logic [CNT_W-1:0] cnt;

    // count down the pending window and clear busy on the last cycle
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy && start) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(LAT);
        end else if (busy) begin
            if (cnt == CNT_W'(1)) busy <= 1'b0;
            cnt <= cnt - CNT_W'(1);
        end
    end

    // completion strobe for the register bank
    assign done = busy && (cnt == CNT_W'(1));

    // R7
    cnt_range_chk: assert property (@(posedge tck) disable iff (!rst_n)
        busy |-> (cnt != '0) && (cnt <= CNT_W'(LAT)));

    // R7
    done_clears_chk: assert property (@(posedge tck) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: rtl/cpdbg_regbank.sv
// Simple coprocessor register bank model.
// Register k sits at A=0, B=0, M=0, N=k. Any other address reads 0 and
// ignores writes. The read result is held for the next capture.
module cpdbg_regbank
    import cpdbg_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr,
    input  cp_addr_t          addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata_q
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [DATA_W-1:0] regs [NUM_REGS];
    logic              hit;
    logic [DATA_W-1:0] rd_sel;

    // address decode for the implemented registers
    assign hit = (addr.fa == 3'd0) && (addr.fb == 3'd0) && (addr.fm == 4'd0)
              && (int'(addr.fn) < NUM_REGS);

    generate
        for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
            // store write data when this register is addressed
            always_ff @(posedge tck) begin
                if (!rst_n) regs[k] <= '0;
                else if (en && wr && hit && (int'(addr.fn) == k)) regs[k] <= wdata;
            end
        end
    endgenerate

    // select the read value, zero on a miss
    assign rd_sel = hit ? regs[addr.fn[IDX_W-1:0]] : '0;

    // latch the read result when a read completes
    always_ff @(posedge tck) begin
        if (!rst_n)        rdata_q <= '0;
        else if (en && !wr) rdata_q <= rd_sel;
    end
endmodule

// File: rtl/cpdbg_chain.sv
// Coprocessor register debug scan chain (top).
// Active only for scan chain CHAIN_ID under the internal-test instruction.
// An update with the request bit set launches an access. The capture
// reports ready and the last read value.
module cpdbg_chain
    import cpdbg_pkg::*;
#(
    parameter int CHAIN_ID = 15,
    parameter int LAT      = 3,
    parameter int NUM_REGS = 8
) (
    input  logic       tck,
    input  logic       rst_n,
    input  logic [3:0] chain_sel,
    input  logic       ir_intest,
    input  logic       capture_dr,
    input  logic       shift_dr,
    input  logic       update_dr,
    input  logic       tdi,
    output logic       tdo
);
    logic              active;
    logic              busy;
    logic              done;
    logic              start;
    chain_t            sr_q;
    chain_t            cap_word;
    logic [DATA_W-1:0] rdata;
    logic              req_wr;
    cp_addr_t          req_addr;
    logic [DATA_W-1:0] req_data;

    // chain selection
    assign active = ir_intest && (chain_sel == 4'(CHAIN_ID));

    // an update with the request bit set asks for an access
    assign start = active && update_dr && sr_q.req;

    // capture image: ready flag and last read result
    always_comb begin
        cap_word      = '0;
        cap_word.req  = !busy;
        cap_word.data = rdata;
    end

    cpdbg_shift i_shift (
        .tck      (tck),
        .rst_n    (rst_n),
        .cap      (active && capture_dr),
        .shf      (active && shift_dr),
        .tdi      (tdi),
        .cap_word (cap_word),
        .sr_q     (sr_q)
    );

    cpdbg_seq #(.LAT(LAT)) i_seq (
        .tck   (tck),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done)
    );

    // hold the accepted command for the whole pending window
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            req_wr   <= 1'b0;
            req_addr <= '0;
            req_data <= '0;
        end else if (start && !busy) begin
            req_wr   <= sr_q.wsel;
            req_addr <= sr_q.addr;
            req_data <= sr_q.data;
        end
    end

    cpdbg_regbank #(.NUM_REGS(NUM_REGS)) i_bank (
        .tck     (tck),
        .rst_n   (rst_n),
        .en      (done),
        .wr      (req_wr),
        .addr    (req_addr),
        .wdata   (req_data),
        .rdata_q (rdata)
    );

    // serial out only while selected
    assign tdo = active ? sr_q.data[0] : 1'b0;

    // R10
    launch_busy_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R8
    nop_idle_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (!busy && active && update_dr && !sr_q.req) |=> !busy);

    // R1
    inactive_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
        !active |=> $stable(sr_q));
endmodule

// File: tb/test_cpdbg_chain.sv
module test_cpdbg_chain;
    localparam int TCK_PERIOD = 10;
    localparam int NREG       = 8;

    logic       tck = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] chain_sel = 4'd15;
    logic       ir_intest = 1'b1;
    logic       capture_dr = 1'b0;
    logic       shift_dr = 1'b0;
    logic       update_dr = 1'b0;
    logic       tdi = 1'b0;
    logic       tdo;

    int total = 0;
    int bad = 0;
    logic [31:0] model [NREG];

    always #(TCK_PERIOD/2) tck = ~tck;

    cpdbg_chain i_cpdbg_chain (
        .tck(tck), .rst_n(rst_n), .chain_sel(chain_sel), .ir_intest(ir_intest),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .tdo(tdo)
    );

    function automatic logic [47:0] cmd(bit wr, logic [13:0] a, bit acc, logic [31:0] d);
        return {wr, a, acc, d};
    endfunction

    function automatic bit is_hit(logic [13:0] a);
        return (a[13:8] == 6'd0) && (a[3:0] == 4'd0) && (int'(a[7:4]) < NREG);
    endfunction

    function automatic logic [31:0] exp_read(logic [13:0] a);
        return is_hit(a) ? model[a[6:4]] : 32'd0;
    endfunction

    task automatic check(string tag, logic [47:0] act, logic [47:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge tck);
            capture_dr = 0; shift_dr = 0; update_dr = 0;
            @(posedge tck);
        end
    endtask

    // capture, 48 shifts, update; ends right after the update edge
    task automatic scan(input logic [47:0] din, input int gap, output logic [47:0] dout);
        idle(gap);
        @(negedge tck);
        capture_dr = 1; shift_dr = 0; update_dr = 0;
        @(posedge tck);
        for (int i = 0; i < 48; i++) begin
            @(negedge tck);
            capture_dr = 0; shift_dr = 1; tdi = din[i];
            dout[i] = tdo;
            @(posedge tck);
        end
        @(negedge tck);
        shift_dr = 0; update_dr = 1;
        @(posedge tck);
    endtask

    task automatic pulse_update();
        @(negedge tck);
        capture_dr = 0; shift_dr = 0; update_dr = 1;
        @(posedge tck);
    endtask

    // launch an access, check the first poll is not ready, then collect result
    task automatic access(bit wr, logic [13:0] a, logic [31:0] d, string tag);
        logic [47:0] r;
        scan(cmd(wr, a, 1'b1, d), 0, r);
        scan(cmd(0, 14'd0, 1'b0, 32'd0), 0, r);
        check({tag, " R7 early poll"}, {47'd0, r[32]}, 48'd0);
        scan(cmd(0, 14'd0, 1'b0, 32'd0), 0, r);
        if (wr) begin
            check({tag, " R4 ready"}, {47'd0, r[32]}, 48'd1);
            if (is_hit(a)) model[a[6:4]] = d;
        end else begin
            check({tag, " R5/R9 read"}, r, {16'd0, 1'b1, exp_read(a)});
        end
    endtask

    initial begin
        repeat (200000) @(posedge tck);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [47:0] r;
        for (int k = 0; k < NREG; k++) model[k] = 32'd0;
        void'($urandom(32'h5eed_c0de));
        repeat (4) @(posedge tck);
        @(negedge tck) rst_n = 1;
        @(posedge tck);

        // R6: reset capture image
        scan(cmd(0, 14'd0, 0, 32'd0), 0, r);
        check("R6 reset image", r, 48'h1_0000_0000);
        access(0, 14'h0030, 32'd0, "R11-ish reset reg3");

        // R2/R3/R4/R5: directed write then read of register 5
        access(1, 14'h0050, 32'hA5A5_1234, "R3 wr reg5");
        access(0, 14'h0050, 32'd0, "R3 rd reg5");
        access(1, 14'h0070, 32'h8000_0001, "R2 wr reg7");
        access(0, 14'h0070, 32'd0, "R2 rd reg7");

        // R9: unimplemented addresses (field A, field B, field M, N beyond range)
        access(1, 14'h0850, 32'hFFFF_FFFF, "R9 wr fa");
        access(1, 14'h0151, 32'hFFFF_FFFF, "R9 wr fm");
        access(0, 14'h0050, 32'd0, "R9 reg5 kept");
        access(0, 14'h0080, 32'd0, "R9 rd unimpl");

        // R7: completion boundary, capture at U+LAT then U+LAT+1
        scan(cmd(1, 14'h0010, 1, 32'h1111_2222), 0, r);
        scan(cmd(0, 14'd0, 0, 32'd0), 2, r);
        check("R7 capture at U+LAT", {47'd0, r[32]}, 48'd0);
        model[1] = 32'h1111_2222;
        scan(cmd(1, 14'h0020, 1, 32'h3333_4444), 0, r);
        scan(cmd(0, 14'd0, 0, 32'd0), 3, r);
        check("R7 capture at U+LAT+1", {47'd0, r[32]}, 48'd1);
        model[2] = 32'h3333_4444;

        // R10: second update one cycle after a launch must not restart
        scan(cmd(1, 14'h0030, 1, 32'hCAFE_0003), 0, r);
        pulse_update();
        scan(cmd(0, 14'd0, 0, 32'd0), 2, r);
        check("R10 no restart", {47'd0, r[32]}, 48'd1);
        model[3] = 32'hCAFE_0003;
        access(0, 14'h0030, 32'd0, "R10 reg3");

        // R8: NOP carrying write data starts nothing and writes nothing
        scan(cmd(1, 14'h0030, 0, 32'hBAD0_BAD0), 0, r);
        scan(cmd(0, 14'd0, 0, 32'd0), 0, r);
        check("R8 nop ready", {47'd0, r[32]}, 48'd1);
        access(0, 14'h0030, 32'd0, "R8 reg3 kept");

        // R1: deselected chain, then wrong instruction
        chain_sel = 4'd14;
        scan(cmd(1, 14'h0020, 1, 32'hDEAD_DEAD), 0, r);
        check("R1 tdo idle sel", r, 48'd0);
        chain_sel = 4'd15; ir_intest = 0;
        scan(cmd(1, 14'h0020, 1, 32'hDEAD_DEAD), 0, r);
        check("R1 tdo idle ir", r, 48'd0);
        ir_intest = 1;
        access(0, 14'h0020, 32'd0, "R1 reg2 kept");

        // random mix
        for (int n = 0; n < 60; n++) begin
            logic [13:0] a;
            bit          w;
            logic [31:0] d;
            if (($urandom % 4) != 0) a = {6'd0, 1'b0, 3'($urandom), 4'd0};
            else                     a = 14'($urandom);
            w = bit'($urandom % 2);
            d = $urandom;
            access(w, a, d, "R4/R5 random");
        end

        idle(2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule